// File: doc/BRIEF.md
# Single-Wire Debug Bit Receiver

This block is the bit-level front end of a target that talks to a debug host over one shared, open-drain style line. The host owns all bit timing. Every bit, in either direction, starts when the host pulls the line low. The target finds that edge and reads the line a fixed number of its own debug-clock ticks later. It builds received bits into bytes, most significant bit first. When the host leaves a long gap between edges, the block raises a timeout that aborts whatever command was under way.

The debug clock is either the block clock itself or a slower alternate source, which enters as a tick enable. All counts below are in debug ticks. The line goes through a two-stage synchronizer before edge detection, so the perceived bit start trails the real edge by a small amount. A layer above the block decides when a bit belongs to a target reply. It does this with a direction input. Bits in the reply direction are timed but not collected, and only then may the line be pulled low. Command decoding and reply timing stay outside the block.

Top module: `sw_bit_engine`

## Requirements
- R1: After reset, rx_valid_o and abort_o are 0, rx_byte_o is 0 and line_oe_no is 1 (line released).
- R2: line_i passes through two synchronizing flops clocked on debug ticks. A high-to-low change at the output of the second flop is a bit start. The line value held in the second flop is sampled on the 10th debug tick after the tick on which the bit start is detected.
- R3: Further falling edges between a bit start and its sample point do not start a new bit.
- R4: Bits are collected most significant first: the first sampled bit of a byte becomes bit 7 of rx_byte_o.
- R5: On the 8th collected bit, rx_byte_o takes the new byte and rx_valid_o is 1 for exactly one clk_i cycle. Collection then restarts from bit 7.
- R6: If 512 debug ticks pass without a bit start, abort_o pulses for one clk_i cycle and any partly collected byte is discarded. No further pulse follows until a new bit start. No pulse occurs after reset before the first bit start.
- R7: line_oe_no is 0 (line driven low) in a cycle only if tx_mode_i and drive_low_i were both 1 in the previous clk_i cycle. Otherwise it is 1.
- R8: A bit whose sample point falls while tx_mode_i is 1 is timed like any other bit but is not collected into the byte.
- R9: With alt_sel_i = 0 every clk_i cycle is a debug tick. With alt_sel_i = 1 only cycles with alt_tick_i = 1 are debug ticks, and every count in R2 and R6 is in those ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_sel_i | input | 1 | Debug clock source: 0 block clock, 1 alternate tick |
| alt_tick_i | input | 1 | Alternate debug clock as a one-cycle enable |
| line_i | input | 1 | Raw level of the shared debug line |
| tx_mode_i | input | 1 | Current bit is a target reply |
| drive_low_i | input | 1 | Request to pull the line low during a reply bit |
| line_oe_no | output | 1 | Active-low output enable pulling the line low |
| rx_byte_o | output | 8 | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new rx_byte_o |
| abort_o | output | 1 | One-cycle timeout pulse aborting the current command |

## Verification
Two host bytes with mixed bit patterns are sent with short-low ones and long-low zeros on the block clock. Together they show bit order and the sample position. The same exchange paced by the alternate tick separates the two clock sources, because any count made in block cycles would sample at the wrong point. A bit with a second falling edge inside its window shows whether bit starts are properly ignored. A partial byte followed by a long gap and then a full byte shows that the abort both fires once and discards the stale bits. Reply-direction bits placed ahead of a received byte show that they are timed but kept out of the data. A reference model checks every clock.

// File: rtl/sw_bit_pkg.sv
package sw_bit_pkg;
  parameter int unsigned DEF_SAMPLE_OFS = 10;
  parameter int unsigned DEF_TIMEOUT    = 512;
  parameter int unsigned DEF_BYTE_W     = 8;
endpackage

// File: rtl/sw_line_sync.sv
module sw_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  logic [2:0] stg_q;

  // stg_q[0..1] synchronize; stg_q[2] holds the previous synchronized level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= 3'b111;
    else if (tick_i) stg_q <= {stg_q[1:0], line_i};
  end

  assign level_o = stg_q[1];
  assign fall_o  = stg_q[2] & ~stg_q[1];
endmodule

// File: rtl/sw_bit_timer.sv
module sw_bit_timer #(
  parameter int unsigned SAMPLE_OFS = sw_bit_pkg::DEF_SAMPLE_OFS,
  parameter int unsigned TIMEOUT    = sw_bit_pkg::DEF_TIMEOUT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fall_i,
  input  logic level_i,
  output logic sample_o,
  output logic bit_o,
  output logic clr_o,
  output logic abort_o
);
  localparam int unsigned CW = $clog2(SAMPLE_OFS);
  localparam int unsigned IW = $clog2(TIMEOUT + 1);

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idle_q;
  logic          abort_q;
  logic          sample_hit, timeout_hit;

  assign sample_hit  = armed_q && (cnt_q == CW'(SAMPLE_OFS - 1));
  assign timeout_hit = !fall_i && (idle_q == IW'(TIMEOUT - 1));
  assign sample_o    = tick_i & sample_hit;
  assign bit_o       = level_i;
  assign clr_o       = tick_i & timeout_hit;
  assign abort_o     = abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      idle_q  <= IW'(TIMEOUT);   // saturated: no abort before first edge
      abort_q <= 1'b0;
    end else begin
      abort_q <= clr_o;
      if (tick_i) begin
        if (timeout_hit) armed_q <= 1'b0;
        else if (armed_q) begin
          if (sample_hit) armed_q <= 1'b0;
          else            cnt_q   <= cnt_q + 1'b1;
        end else if (fall_i) begin
          armed_q <= 1'b1;
          cnt_q   <= '0;
        end
        if (fall_i)                      idle_q <= '0;
        else if (idle_q != IW'(TIMEOUT)) idle_q <= idle_q + 1'b1;
      end
    end
  end

  // R6
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
endmodule

// File: rtl/sw_byte_shift.sv
module sw_byte_shift #(
  parameter int unsigned BYTE_W = sw_bit_pkg::DEF_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              rx_en_i,
  input  logic              clr_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  localparam int unsigned BW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q, byte_q;
  logic [BW-1:0]     cnt_q;
  logic              valid_q;
  logic              take, last;

  assign take = sample_i && rx_en_i && !clr_i;
  assign last = (cnt_q == BW'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      byte_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= take && last;
      if (clr_i) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (take) begin
        if (last) begin
          byte_q <= {sh_q[BYTE_W-2:0], bit_i};
          sh_q   <= '0;
          cnt_q  <= '0;
        end else begin
          sh_q  <= {sh_q[BYTE_W-2:0], bit_i};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R5
  valid_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(sample_i));
endmodule

// File: rtl/sw_bit_engine.sv
module sw_bit_engine #(
  parameter int unsigned SAMPLE_OFS = sw_bit_pkg::DEF_SAMPLE_OFS,
  parameter int unsigned TIMEOUT    = sw_bit_pkg::DEF_TIMEOUT,
  parameter int unsigned BYTE_W     = sw_bit_pkg::DEF_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alt_sel_i,
  input  logic              alt_tick_i,
  input  logic              line_i,
  input  logic              tx_mode_i,
  input  logic              drive_low_i,
  output logic              line_oe_no,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              abort_o
);
  logic tick, level, fall, sample, bit_v, clr;
  logic oe_nq;

  assign tick = alt_sel_i ? alt_tick_i : 1'b1;

  sw_line_sync u_sync (
    .clk_i, .rst_ni, .tick_i(tick), .line_i,
    .level_o(level), .fall_o(fall)
  );

  sw_bit_timer #(.SAMPLE_OFS(SAMPLE_OFS), .TIMEOUT(TIMEOUT)) u_timer (
    .clk_i, .rst_ni, .tick_i(tick), .fall_i(fall), .level_i(level),
    .sample_o(sample), .bit_o(bit_v), .clr_o(clr), .abort_o
  );

  sw_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .sample_i(sample), .bit_i(bit_v), .rx_en_i(!tx_mode_i),
    .clr_i(clr), .byte_o(rx_byte_o), .valid_o(rx_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_nq <= 1'b1;
    else         oe_nq <= ~(tx_mode_i & drive_low_i);
  end
  assign line_oe_no = oe_nq;

  // R7
  oe_rx_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tx_mode_i) |-> line_oe_no);
endmodule

// File: tb/sim_sw_bit_engine.sv
module sim_sw_bit_engine;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic alt_sel_i = 1'b0, alt_tick_i = 1'b0, line_i = 1'b1;
  logic tx_mode_i = 1'b0, drive_low_i = 1'b0;
  logic line_oe_no, rx_valid_o, abort_o;
  logic [7:0] rx_byte_o;

  int checks = 0, errors = 0;
  int aborts = 0, valids = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  sw_bit_engine u0 (.*);

  // reference model state
  bit   hist[$];
  bit   bits[$];
  int   cd, idle;
  logic e_valid, e_abort, e_oe;
  logic [7:0] e_byte;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{1'b1, 1'b1, 1'b1};
      bits.delete();
      cd = 0; idle = 512;
      e_valid = 0; e_abort = 0; e_oe = 1; e_byte = 8'h00;
    end else begin
      bit tk, fl;
      tk = alt_sel_i ? alt_tick_i : 1'b1;
      e_valid = 0; e_abort = 0;
      e_oe = !(tx_mode_i && drive_low_i);
      if (tk) begin
        fl = hist[2] && !hist[1];
        if (cd > 0) begin
          cd--;
          if (cd == 0 && !tx_mode_i) begin
            bits.push_back(hist[1]);
            if (bits.size() == 8) begin
              logic [7:0] v;
              v = 0;
              foreach (bits[i]) v = {v[6:0], bits[i]};
              e_byte = v; e_valid = 1; bits.delete();
            end
          end
        end else if (fl) cd = 10;
        if (fl) idle = 0;
        else if (idle < 512) begin
          idle++;
          if (idle == 512) begin e_abort = 1; bits.delete(); cd = 0; end
        end
        hist.push_front(line_i);
        void'(hist.pop_back());
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) if (rst_ni && !done) begin
    chk(rx_valid_o == e_valid, "R5 rx_valid_o", rx_valid_o, e_valid);
    chk(rx_byte_o == e_byte, "R4 rx_byte_o", rx_byte_o, e_byte);
    chk(abort_o == e_abort, "R6 abort_o", abort_o, e_abort);
    chk(line_oe_no == e_oe, "R7 line_oe_no", line_oe_no, e_oe);
    if (abort_o) aborts++;
    if (rx_valid_o) valids++;
  end

  initial begin
    forever begin
      repeat (2) @(negedge clk_i);
      alt_tick_i = 1'b1;
      @(negedge clk_i);
      alt_tick_i = 1'b0;
    end
  end

  task automatic host_bit(input bit b, input int sc, input bit glitch);
    line_i = 1'b0;
    repeat ((b ? 4 : 12) * sc) @(negedge clk_i);
    line_i = 1'b1;
    if (glitch) begin
      repeat (2 * sc) @(negedge clk_i);
      line_i = 1'b0;
      repeat (2 * sc) @(negedge clk_i);
      line_i = 1'b1;
      repeat (8 * sc) @(negedge clk_i);
    end else
      repeat ((b ? 12 : 4) * sc) @(negedge clk_i);
  endtask

  task automatic host_byte(input logic [7:0] v, input int sc);
    for (int i = 7; i >= 0; i--) host_bit(v[i], sc, 1'b0);
    repeat (3 * sc) @(negedge clk_i);
  endtask

  initial begin
    int a0, v0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(rx_valid_o == 0 && abort_o == 0 && rx_byte_o == 0 && line_oe_no == 1,
        "R1 reset state", {rx_valid_o, abort_o, line_oe_no}, 3'b001);
    // R2 R4 R5: bus clock
    host_byte(8'hA5, 1);
    chk(rx_byte_o == 8'hA5, "R4 byte A5", rx_byte_o, 8'hA5);
    host_byte(8'h3C, 1);
    chk(rx_byte_o == 8'h3C, "R2 byte 3C", rx_byte_o, 8'h3C);
    chk(valids == 2, "R5 strobes", valids, 2);
    // R3: extra edges inside the window
    for (int i = 0; i < 8; i++) host_bit(1'b1, 1, (i % 2) == 0);
    repeat (3) @(negedge clk_i);
    chk(rx_byte_o == 8'hFF, "R3 glitch byte", rx_byte_o, 8'hFF);
    // R6: partial byte then long gap
    a0 = aborts;
    host_bit(1'b0, 1, 1'b0); host_bit(1'b0, 1, 1'b0); host_bit(1'b0, 1, 1'b0);
    repeat (1200) @(negedge clk_i);
    chk(aborts == a0 + 1, "R6 single abort", aborts, a0 + 1);
    host_byte(8'hC3, 1);
    chk(rx_byte_o == 8'hC3, "R6 partial discarded", rx_byte_o, 8'hC3);
    // R8 R7: reply bits not collected, line driven only in reply mode
    tx_mode_i = 1'b1; drive_low_i = 1'b1;
    @(negedge clk_i);
    chk(line_oe_no == 1'b0, "R7 drive low", line_oe_no, 0);
    drive_low_i = 1'b0;
    v0 = valids;
    for (int i = 0; i < 4; i++) host_bit(1'b0, 1, 1'b0);
    tx_mode_i = 1'b0; drive_low_i = 1'b1;
    @(negedge clk_i);
    chk(line_oe_no == 1'b1, "R7 no drive in rx", line_oe_no, 1);
    drive_low_i = 1'b0;
    host_byte(8'h5A, 1);
    chk(rx_byte_o == 8'h5A && valids == v0 + 1, "R8 reply bits skipped", rx_byte_o, 8'h5A);
    // R9: alternate tick
    alt_sel_i = 1'b1;
    repeat (3) @(negedge clk_i);
    host_byte(8'h96, 3);
    chk(rx_byte_o == 8'h96, "R9 alt clock byte", rx_byte_o, 8'h96);
    a0 = aborts;
    repeat (1700) @(negedge clk_i);
    chk(aborts == a0 + 1, "R9 alt timeout", aborts, a0 + 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule